// File: doc/BRIEF.md
# Clear-on-read status readback sequencer

This block answers a read transaction with a fixed run of three status bytes. The first is a flag byte. The second is an 8-bit signal level. The third packs two 4-bit noise measures. A serial front end outside this block asks for each byte with `byte_req_i`. It then marks the close of the transaction with `read_end_i`. The byte to shift out next is always on `byte_o`.

Two pieces of state make the readback more than a plain multiplexer.

A sticky power-up flag is set by reset or by a supply event. It drops only when a transaction that delivered it finishes.

The measurement bytes normally follow the main source. While an alternate-source update runs, they follow the alternate source instead. Once the update stops, the last alternate values are frozen until one transaction has read them out. After that read they fall back to the live main values.

Top module: `status_readback`

## Requirements
- R1: After reset the sequencer points at the flag byte, the power-up flag is 1 and the sample-mode flag is 0. With all inputs low, `byte_o` reads 8'h14.
- R2: The flag byte is laid out as {stereo, step_busy, sample_mode, power_up, 1'b0, 3'b100}. Bit 7 is the stereo input, bit 6 the audio-step input, bit 5 sample mode and bit 4 the power-up flag. Bit 3 is 0 and bits 2:0 are the fixed ID 100.
- R3: Each `byte_req_i` advances the sequence by one byte: flag, then level, then {noise[3:0], wideband[3:0]}. Noise sits in bits 7:4 and wideband in bits 3:0.
- R4: Requests after the third byte return the flag byte again. They clear nothing and set nothing.
- R5: `read_end_i` returns the sequence to the flag byte. When it arrives in the same cycle as `byte_req_i`, the request is ignored.
- R6: The power-up flag clears on the `read_end_i` of a transaction that delivered the flag byte while the flag was 1. It never clears during the transaction, and a transaction that delivered no flag byte leaves it set.
- R7: `supply_event_i` sets the power-up flag. This takes priority over a clearing `read_end_i` in the same cycle, and a delivery made before the event no longer counts.
- R8: With no update running and nothing held, sample mode reads 0, and the level and noise bytes show the live main-source inputs.
- R9: While `alt_update_i` is high, sample mode reads 1 and the measurement bytes show the live alternate-source inputs.
- R10: After `alt_update_i` falls, sample mode stays 1. The measurement bytes keep the alternate values of the last update cycle, whatever the inputs do afterwards.
- R11: Held values revert to live main values on the `read_end_i` of a transaction that delivered the level or noise byte while they were held. A transaction that delivered neither keeps them held.
- R12: A new update that starts while values are held returns the measurement bytes to live alternate tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stereo_i | input | 1 | Live stereo indicator |
| step_busy_i | input | 1 | Audio step in progress |
| supply_event_i | input | 1 | Supply disturbance strobe, sets the power-up flag |
| alt_update_i | input | 1 | Alternate-source update in progress |
| main_level_i | input | 8 | Main-source level |
| main_noise_i | input | 4 | Main-source noise measure |
| main_wide_i | input | 4 | Main-source wideband measure |
| alt_level_i | input | 8 | Alternate-source level |
| alt_noise_i | input | 4 | Alternate-source noise measure |
| alt_wide_i | input | 4 | Alternate-source wideband measure |
| byte_req_i | input | 1 | Current byte consumed, advance to the next |
| read_end_i | input | 1 | End of read transaction |
| byte_o | output | 8 | Byte to shift out next |

## Verification
Directed sequences first take the measurement source through each phase: main only, update running, update ended and held, held then read, and held then interrupted by a new update. Each phase's bytes are compared against distinct values on the main and alternate inputs, so showing the wrong source cannot go unnoticed.

Transactions of differing lengths show how clear-on-read depends on which bytes were delivered:
- empty transactions;
- flag-only transactions;
- transactions that run past the third byte;
- transactions whose end collides with a request or a supply event.

Reads past the third byte separate flag-byte repetition from side effects on the sticky flags. A long seeded random run then mixes all strobes against a bench reference model.

// File: rtl/status_readback_pkg.sv
package status_readback_pkg;
    localparam int LVL_W = 8;
    localparam int NS_W  = 4;
    localparam logic [2:0] DEVICE_ID = 3'b100;

    typedef enum logic [1:0] {
        SEL_FLAGS = 2'd0,
        SEL_LEVEL = 2'd1,
        SEL_NOISE = 2'd2,
        SEL_PAST  = 2'd3
    } byte_sel_e;
endpackage

// File: rtl/rdb_index.sv
module rdb_index
    import status_readback_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      byte_req_i,
    input  logic      read_end_i,
    output byte_sel_e sel_o,
    output logic      took_flags_o,
    output logic      took_meas_o
);
    typedef struct packed {
        byte_sel_e sel;
    } idx_state_t;

    idx_state_t st_d, st_q;
    logic       accept;

    always_comb begin
        st_d   = st_q;
        accept = byte_req_i && !read_end_i;
        if (read_end_i) begin
            st_d.sel = SEL_FLAGS;
        end else if (accept && st_q.sel != SEL_PAST) begin
            st_d.sel = byte_sel_e'(st_q.sel + 2'd1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sel: SEL_FLAGS};
        else        st_q <= st_d;
    end

    assign sel_o        = st_q.sel;
    assign took_flags_o = accept && (st_q.sel == SEL_FLAGS);
    assign took_meas_o  = accept && (st_q.sel == SEL_LEVEL || st_q.sel == SEL_NOISE);
endmodule

// File: rtl/rdb_sticky.sv
module rdb_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_event_i,
    input  logic took_flags_i,
    input  logic read_end_i,
    output logic power_up_o
);
    typedef struct packed {
        logic flag;
        logic seen;
    } sticky_t;

    sticky_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (supply_event_i) begin
            st_d.flag = 1'b1;
            st_d.seen = 1'b0;
        end else if (read_end_i) begin
            if (st_q.seen) st_d.flag = 1'b0;
            st_d.seen = 1'b0;
        end else if (took_flags_i && st_q.flag) begin
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flag: 1'b1, seen: 1'b0};
        else        st_q <= st_d;
    end

    assign power_up_o = st_q.flag;
endmodule

// File: rtl/rdb_meas_hold.sv
module rdb_meas_hold #(
    parameter int LVL_W = 8,
    parameter int NS_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alt_update_i,
    input  logic [LVL_W-1:0] alt_level_i,
    input  logic [NS_W-1:0]  alt_noise_i,
    input  logic [NS_W-1:0]  alt_wide_i,
    input  logic             took_meas_i,
    input  logic             read_end_i,
    output logic             held_o,
    output logic [LVL_W-1:0] held_level_o,
    output logic [NS_W-1:0]  held_noise_o,
    output logic [NS_W-1:0]  held_wide_o
);
    typedef struct packed {
        logic             held;
        logic             seen;
        logic [LVL_W-1:0] level;
        logic [NS_W-1:0]  noise;
        logic [NS_W-1:0]  wide;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (alt_update_i) begin
            st_d.held  = 1'b1;
            st_d.seen  = 1'b0;
            st_d.level = alt_level_i;
            st_d.noise = alt_noise_i;
            st_d.wide  = alt_wide_i;
        end else if (read_end_i) begin
            if (st_q.seen) st_d.held = 1'b0;
            st_d.seen = 1'b0;
        end else if (took_meas_i && st_q.held) begin
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_o       = st_q.held;
    assign held_level_o = st_q.level;
    assign held_noise_o = st_q.noise;
    assign held_wide_o  = st_q.wide;
endmodule

// File: rtl/status_readback.sv
module status_readback
    import status_readback_pkg::*;
#(
    parameter int LEVEL_W = LVL_W,
    parameter int MEAS_W  = NS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stereo_i,
    input  logic               step_busy_i,
    input  logic               supply_event_i,
    input  logic               alt_update_i,
    input  logic [LEVEL_W-1:0] main_level_i,
    input  logic [MEAS_W-1:0]  main_noise_i,
    input  logic [MEAS_W-1:0]  main_wide_i,
    input  logic [LEVEL_W-1:0] alt_level_i,
    input  logic [MEAS_W-1:0]  alt_noise_i,
    input  logic [MEAS_W-1:0]  alt_wide_i,
    input  logic               byte_req_i,
    input  logic               read_end_i,
    output logic [LEVEL_W-1:0] byte_o
);
    localparam int BYTE_W = LEVEL_W;

    byte_sel_e          sel;
    logic               took_flags, took_meas, power_up, held;
    logic [LEVEL_W-1:0] held_level, lvl_src;
    logic [MEAS_W-1:0]  held_noise, held_wide, noise_src, wide_src;
    logic               sample_mode;
    logic [BYTE_W-1:0]  flag_byte;

    rdb_index u_index (
        .clk(clk), .rst_n(rst_n),
        .byte_req_i(byte_req_i), .read_end_i(read_end_i),
        .sel_o(sel), .took_flags_o(took_flags), .took_meas_o(took_meas)
    );

    rdb_sticky u_sticky (
        .clk(clk), .rst_n(rst_n),
        .supply_event_i(supply_event_i), .took_flags_i(took_flags),
        .read_end_i(read_end_i), .power_up_o(power_up)
    );

    rdb_meas_hold #(.LVL_W(LEVEL_W), .NS_W(MEAS_W)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .alt_update_i(alt_update_i),
        .alt_level_i(alt_level_i), .alt_noise_i(alt_noise_i), .alt_wide_i(alt_wide_i),
        .took_meas_i(took_meas), .read_end_i(read_end_i),
        .held_o(held), .held_level_o(held_level),
        .held_noise_o(held_noise), .held_wide_o(held_wide)
    );

    always_comb begin
        sample_mode = alt_update_i || held;
        if (alt_update_i) begin
            lvl_src   = alt_level_i;
            noise_src = alt_noise_i;
            wide_src  = alt_wide_i;
        end else if (held) begin
            lvl_src   = held_level;
            noise_src = held_noise;
            wide_src  = held_wide;
        end else begin
            lvl_src   = main_level_i;
            noise_src = main_noise_i;
            wide_src  = main_wide_i;
        end
        flag_byte = '0;
        flag_byte[BYTE_W-1] = stereo_i;
        flag_byte[BYTE_W-2] = step_busy_i;
        flag_byte[BYTE_W-3] = sample_mode;
        flag_byte[BYTE_W-4] = power_up;
        flag_byte[2:0]      = DEVICE_ID;
        case (sel)
            SEL_LEVEL: byte_o = lvl_src;
            SEL_NOISE: byte_o = {noise_src, wide_src};
            default:   byte_o = flag_byte;
        endcase
    end
endmodule

// File: rtl/status_readback_checker.sv
module status_readback_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_event_i,
    input logic       alt_update_i,
    input logic       byte_req_i,
    input logic       read_end_i,
    input logic [1:0] sel,
    input logic       power_up,
    input logic [7:0] byte_o
);
    AST_END_TO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        read_end_i |=> sel == 2'd0); // R5

    AST_PAST_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd3 && byte_req_i && !read_end_i) |=> sel == 2'd3); // R4

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        supply_event_i |=> power_up); // R7

    AST_NO_MID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (power_up && !read_end_i) |=> power_up); // R6

    AST_UPDATE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_update_i && sel == 2'd0) |-> byte_o[5]); // R9

    AST_ID_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd0 || sel == 2'd3) |-> byte_o[3:0] == 4'b0100); // R2
endmodule

bind status_readback status_readback_checker u_chk (
    .clk(clk), .rst_n(rst_n), .supply_event_i(supply_event_i),
    .alt_update_i(alt_update_i), .byte_req_i(byte_req_i), .read_end_i(read_end_i),
    .sel(sel), .power_up(power_up), .byte_o(byte_o)
);

// File: tb/tb_status_readback.sv
module tb_status_readback;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stereo, step, sup, upd, req, rend;
    logic [7:0] m_lvl, a_lvl;
    logic [3:0] m_ns, m_wm, a_ns, a_wm;
    logic [7:0] byte_o;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int         e_idx;
    logic       e_por, e_pseen, e_held, e_mseen;
    logic [7:0] e_hl;
    logic [3:0] e_hn, e_hw;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_readback dut (
        .clk(clk), .rst_n(rst_n), .stereo_i(stereo), .step_busy_i(step),
        .supply_event_i(sup), .alt_update_i(upd),
        .main_level_i(m_lvl), .main_noise_i(m_ns), .main_wide_i(m_wm),
        .alt_level_i(a_lvl), .alt_noise_i(a_ns), .alt_wide_i(a_wm),
        .byte_req_i(req), .read_end_i(rend), .byte_o(byte_o)
    );

    function automatic logic [7:0] expect_byte();
        logic [7:0] lv;
        logic [3:0] ns, wm;
        logic       smp;
        smp = upd | e_held;
        if (upd)         begin lv = a_lvl; ns = a_ns; wm = a_wm; end
        else if (e_held) begin lv = e_hl;  ns = e_hn; wm = e_hw; end
        else             begin lv = m_lvl; ns = m_ns; wm = m_wm; end
        case (e_idx)
            1:       return lv;
            2:       return {ns, wm};
            default: return {stereo, step, smp, e_por, 1'b0, 3'b100};
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s byte_o=%h expected=%h (idx %0d)", tag, got, exp, e_idx);
        end
    endtask

    task automatic model_advance();
        int i;
        i = e_idx;
        if (sup) begin e_por = 1'b1; e_pseen = 1'b0; end
        else if (rend) begin if (e_pseen) e_por = 1'b0; e_pseen = 1'b0; end
        else if (req && i == 0 && e_por) e_pseen = 1'b1;
        if (upd) begin
            e_held = 1'b1; e_mseen = 1'b0; e_hl = a_lvl; e_hn = a_ns; e_hw = a_wm;
        end else if (rend) begin if (e_mseen) e_held = 1'b0; e_mseen = 1'b0; end
        else if (req && (i == 1 || i == 2) && e_held) e_mseen = 1'b1;
        if (rend) e_idx = 0;
        else if (req && i != 3) e_idx = i + 1;
    endtask

    // inputs already set at a falling edge; check, then cross the rising edge
    task automatic step_chk(input string tag);
        #1;
        check(tag, byte_o, expect_byte());
        model_advance();
        @(negedge clk);
        req = 0; rend = 0; sup = 0;
    endtask

    task automatic idle_inputs();
        stereo = 0; step = 0; sup = 0; upd = 0; req = 0; rend = 0;
        m_lvl = 8'h00; m_ns = 4'h0; m_wm = 4'h0;
        a_lvl = 8'h00; a_ns = 4'h0; a_wm = 4'h0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        idle_inputs();
        e_idx = 0; e_por = 1; e_pseen = 0; e_held = 0; e_mseen = 0;
        e_hl = 0; e_hn = 0; e_hw = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1", byte_o, 8'h14);

        // R2: flag bits from live inputs
        stereo = 1; step = 1; step_chk("R2");
        stereo = 0; step = 1; step_chk("R2");

        // R8 and R3: main source values in order, then R4 repeats
        m_lvl = 8'hA5; m_ns = 4'h3; m_wm = 4'hC;
        a_lvl = 8'h5A; a_ns = 4'h9; a_wm = 4'h6;
        req = 1; step_chk("R3");
        req = 1; step_chk("R8");
        req = 1; step_chk("R8");
        req = 1; step_chk("R4");
        req = 1; step_chk("R4");
        rend = 1; step_chk("R4");
        // R6: flag byte delivered above with power-up set -> now cleared
        step_chk("R6");
        if (byte_o[4] !== 1'b0) begin checks++; fails++; $display("FAIL R6 por=%b expected=0", byte_o[4]); end
        else checks++;

        // R7: event sets; empty transaction keeps it
        sup = 1; step_chk("R7");
        rend = 1; step_chk("R6");
        step_chk("R6");
        // R7: event colliding with clearing end
        req = 1; step_chk("R6");
        rend = 1; sup = 1; step_chk("R7");
        step_chk("R7");
        // R5: request ignored when end arrives with it
        req = 1; step_chk("R5");
        req = 1; rend = 1; step_chk("R5");
        step_chk("R5");

        // R9: update running
        upd = 1; step_chk("R9");
        req = 1; step_chk("R9");
        a_lvl = 8'h77; step_chk("R9");
        a_ns = 4'hE; a_wm = 4'h1; req = 1; step_chk("R9");
        upd = 0; rend = 1; step_chk("R10");
        // R10: held despite alt changes
        a_lvl = 8'h00; a_ns = 4'h0; a_wm = 4'h0; step_chk("R10");
        rend = 1; step_chk("R11");   // empty read keeps hold
        req = 1; step_chk("R10");
        req = 1; step_chk("R10");
        step_chk("R10");
        rend = 1; step_chk("R11");
        step_chk("R11");
        req = 1; step_chk("R11");
        step_chk("R11");            // main level now
        rend = 1; step_chk("R11");
        // R12: new update during hold
        upd = 1; a_lvl = 8'h3C; step_chk("R12");
        upd = 0; req = 1; step_chk("R12");
        step_chk("R12");
        upd = 1; a_lvl = 8'hC3; step_chk("R12");
        upd = 0; rend = 1; step_chk("R12");

        // seeded random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            stereo = 1'($urandom); step = 1'($urandom);
            m_lvl = 8'($urandom); m_ns = 4'($urandom); m_wm = 4'($urandom);
            a_lvl = 8'($urandom); a_ns = 4'($urandom); a_wm = 4'($urandom);
            if ($urandom_range(0, 15) == 0) upd = ~upd;
            sup  = ($urandom_range(0, 63) == 0);
            req  = ($urandom_range(0, 1) == 0);
            rend = ($urandom_range(0, 7) == 0);
            step_chk(e_idx == 1 || e_idx == 2 ? "R3" : "R2");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule